// File: doc/BRIEF.md
# Segmented Real-Mode Address Generator

This unit turns a segment value and an effective offset into a 20-bit physical address in the way a 16-bit segmented processor does in real mode. The segment value is shifted left by four bits and the 16-bit offset is added to it. The offset comes from one of several operand addressing forms: a plain displacement, a single pointer register, a pointer register plus a displacement, or a base register plus an index register. It can also come from two fixed forms, an instruction fetch at the instruction pointer and a stack push below the stack pointer.

The segment register is picked without being named. Any form that involves the frame pointer BP uses the stack segment, a fetch uses the code segment, a push uses the stack segment, and everything else uses the data segment. For data accesses, an explicit override input can replace that choice. Along with the address, the unit reports which segment it chose and that segment's first and last byte addresses.

A request strobe loads the result into output registers. A valid strobe follows one cycle later, and the outputs hold until the next request.

Top module: `segAddrGen`

## Requirements
- R1: `physAddr` equals (segment value × 16) + effective offset, taken modulo 2^20. The effective offset is formed modulo 2^16 before that addition.
- R2: Mode code 0 (direct) uses `disp` as the offset. Mode codes 6 and 7 behave exactly like mode code 0.
- R3: Mode code 1 (indirect) uses the register named by `ptrSel` as the offset, where 0=BX, 1=BP, 2=SI, 3=DI. `disp` is ignored.
- R4: Mode code 2 (relative) uses the `ptrSel` register plus `disp`, modulo 2^16.
- R5: Mode code 3 (base plus index) uses the base (`baseSel` 0=BX, 1=BP) plus the index (`idxSel` 0=SI, 1=DI), modulo 2^16. `disp` is ignored.
- R6: With no override, modes 0–3 and 6–7 select SS when BP takes part in the offset and DS otherwise. `segSel` encodes 0=ES, 1=CS, 2=SS, 3=DS.
- R7: In modes 0–3 and 6–7, when `ovrEn` is 1 the segment is `ovrSeg` (same encoding as R6), whatever register took part.
- R8: Mode code 4 (fetch) uses CS with offset `ipVal`. `ovrEn` has no effect.
- R9: Mode code 5 (push) uses SS with offset `spVal`−2, modulo 2^16. `ovrEn` has no effect.
- R10: `segStart` equals the chosen segment value × 16. `segEnd` equals `segStart` + FFFFH, modulo 2^20.
- R11: `outValid` is 1 exactly in the cycle after a cycle with `reqValid`=1. The outputs take the new result in that cycle and hold while `reqValid` is 0.
- R12: While `rstN` is low and after its release, all outputs read 0 until the first request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request strobe; loads the result |
| modeCode | input | 3 | Addressing form code |
| ptrSel | input | 2 | Register for indirect/relative forms |
| baseSel | input | 1 | Base register for base-plus-index |
| idxSel | input | 1 | Index register for base-plus-index |
| ovrEn | input | 1 | Segment override enable |
| ovrSeg | input | 2 | Override segment code |
| bxVal | input | 16 | BX value |
| bpVal | input | 16 | BP value |
| siVal | input | 16 | SI value |
| diVal | input | 16 | DI value |
| spVal | input | 16 | Stack pointer value |
| ipVal | input | 16 | Instruction pointer value |
| disp | input | 16 | Displacement |
| esVal | input | 16 | ES value |
| csVal | input | 16 | CS value |
| ssVal | input | 16 | SS value |
| dsVal | input | 16 | DS value |
| outValid | output | 1 | Result valid strobe |
| physAddr | output | 20 | Physical address |
| segSel | output | 2 | Chosen segment code |
| segStart | output | 20 | First byte of chosen segment |
| segEnd | output | 20 | Last byte of chosen segment |

## Verification
The sweep crosses every mode code with every pointer, base and index select and with every override setting, so a wrong register or a wrong implicit segment shows up as a mismatch in `segSel` or `physAddr`. Each combination runs under three register patterns:
- Distinct small values, which separate one register from another.
- Values near FFFFH, which exercise the 16-bit offset wrap and the 20-bit address wrap.
- A scrambled set, which catches crossed bits.

Directed cases pin the known results 21100H for SS:BP+DI and 21000H for CS:IP, the 10000H–1FFFFH span, and the push wrap at SP=0. An idle cycle after each request, with the inputs scrambled, shows that the outputs hold.

// File: rtl/segAddrPkg.sv
package segAddrPkg;

  localparam logic [2:0] MODE_DIRECT   = 3'd0;
  localparam logic [2:0] MODE_INDIRECT = 3'd1;
  localparam logic [2:0] MODE_RELATIVE = 3'd2;
  localparam logic [2:0] MODE_BASEIDX  = 3'd3;
  localparam logic [2:0] MODE_FETCH    = 3'd4;
  localparam logic [2:0] MODE_PUSH     = 3'd5;

  localparam logic [1:0] PTR_BX = 2'd0;
  localparam logic [1:0] PTR_BP = 2'd1;
  localparam logic [1:0] PTR_SI = 2'd2;
  localparam logic [1:0] PTR_DI = 2'd3;

  typedef enum logic [1:0] {
    SEG_ES = 2'd0,
    SEG_CS = 2'd1,
    SEG_SS = 2'd2,
    SEG_DS = 2'd3
  } segCode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadEn;
  } ctlStrobe_t;

endpackage

// File: rtl/segAddrOffset.sv
module segAddrOffset
  import segAddrPkg::*;
#(
  parameter int REG_W     = 16,
  parameter int PUSH_STEP = 2
) (
  input  logic [2:0]       modeCode,
  input  logic [1:0]       ptrSel,
  input  logic             baseSel,
  input  logic             idxSel,
  input  logic [REG_W-1:0] bxVal,
  input  logic [REG_W-1:0] bpVal,
  input  logic [REG_W-1:0] siVal,
  input  logic [REG_W-1:0] diVal,
  input  logic [REG_W-1:0] spVal,
  input  logic [REG_W-1:0] ipVal,
  input  logic [REG_W-1:0] disp,
  output logic [REG_W-1:0] effOff,
  output logic             usesBp
);

  logic [REG_W-1:0] ptrVal;
  logic [REG_W-1:0] baseVal;
  logic [REG_W-1:0] idxVal;

  always_comb begin
    unique case (ptrSel)
      PTR_BX:  ptrVal = bxVal;
      PTR_BP:  ptrVal = bpVal;
      PTR_SI:  ptrVal = siVal;
      default: ptrVal = diVal;
    endcase
  end

  assign baseVal = baseSel ? bpVal : bxVal;
  assign idxVal  = idxSel  ? diVal : siVal;

  // all sums are REG_W wide, so they wrap modulo 2^REG_W
  always_comb begin
    effOff = disp;
    usesBp = 1'b0;
    case (modeCode)
      MODE_INDIRECT: begin
        effOff = ptrVal;
        usesBp = (ptrSel == PTR_BP);
      end
      MODE_RELATIVE: begin
        effOff = ptrVal + disp;
        usesBp = (ptrSel == PTR_BP);
      end
      MODE_BASEIDX: begin
        effOff = baseVal + idxVal;
        usesBp = baseSel;
      end
      MODE_FETCH: effOff = ipVal;
      MODE_PUSH:  effOff = spVal - REG_W'(PUSH_STEP);
      default: begin
        effOff = disp;
        usesBp = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/segAddrCtrl.sv
module segAddrCtrl
  import segAddrPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  output ctlStrobe_t ctl,
  output logic       outValid
);

  assign ctl.loadEn = reqValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= reqValid;
  end

  p_valid_lag_r11: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> outValid);

  p_no_spurious_valid_r11: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !outValid);

endmodule

// File: rtl/segAddrDatapath.sv
module segAddrDatapath
  import segAddrPkg::*;
#(
  parameter int REG_W     = 16,
  parameter int SHIFT     = 4,
  parameter int PUSH_STEP = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctlStrobe_t             ctl,
  input  logic [2:0]             modeCode,
  input  logic [1:0]             ptrSel,
  input  logic                   baseSel,
  input  logic                   idxSel,
  input  logic                   ovrEn,
  input  logic [1:0]             ovrSeg,
  input  logic [REG_W-1:0]       bxVal,
  input  logic [REG_W-1:0]       bpVal,
  input  logic [REG_W-1:0]       siVal,
  input  logic [REG_W-1:0]       diVal,
  input  logic [REG_W-1:0]       spVal,
  input  logic [REG_W-1:0]       ipVal,
  input  logic [REG_W-1:0]       disp,
  input  logic [REG_W-1:0]       esVal,
  input  logic [REG_W-1:0]       csVal,
  input  logic [REG_W-1:0]       ssVal,
  input  logic [REG_W-1:0]       dsVal,
  output logic [REG_W+SHIFT-1:0] physAddr,
  output logic [1:0]             segSel,
  output logic [REG_W+SHIFT-1:0] segStart,
  output logic [REG_W+SHIFT-1:0] segEnd
);

  localparam int ADDR_W = REG_W + SHIFT;
  localparam logic [ADDR_W-1:0] SEG_SPAN = ADDR_W'(1) << REG_W;
  localparam logic [ADDR_W-1:0] SEG_LAST = SEG_SPAN - ADDR_W'(1);

  logic [REG_W-1:0]  effOff;
  logic              usesBp;
  segCode_e          segCode;
  logic [REG_W-1:0]  segVal;
  logic [ADDR_W-1:0] segBase;
  logic [ADDR_W-1:0] physNext;
  logic [ADDR_W-1:0] endNext;

  segAddrOffset #(.REG_W(REG_W), .PUSH_STEP(PUSH_STEP)) u_offset (
    .modeCode(modeCode), .ptrSel(ptrSel), .baseSel(baseSel), .idxSel(idxSel),
    .bxVal(bxVal), .bpVal(bpVal), .siVal(siVal), .diVal(diVal),
    .spVal(spVal), .ipVal(ipVal), .disp(disp),
    .effOff(effOff), .usesBp(usesBp)
  );

  // implicit segment, overridable only for data forms
  always_comb begin
    case (modeCode)
      MODE_FETCH: segCode = SEG_CS;
      MODE_PUSH:  segCode = SEG_SS;
      default: begin
        if (ovrEn)       segCode = segCode_e'(ovrSeg);
        else if (usesBp) segCode = SEG_SS;
        else             segCode = SEG_DS;
      end
    endcase
  end

  always_comb begin
    unique case (segCode)
      SEG_ES:  segVal = esVal;
      SEG_CS:  segVal = csVal;
      SEG_SS:  segVal = ssVal;
      default: segVal = dsVal;
    endcase
  end

  assign segBase  = {segVal, {SHIFT{1'b0}}};
  assign physNext = segBase + ADDR_W'(effOff);
  assign endNext  = segBase + SEG_LAST;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      physAddr <= '0;
      segSel   <= '0;
      segStart <= '0;
      segEnd   <= '0;
    end else if (ctl.loadEn) begin
      physAddr <= physNext;
      segSel   <= segCode;
      segStart <= segBase;
      segEnd   <= endNext;
    end
  end

  p_end_span_r10: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadEn |=> (ADDR_W'(segEnd - segStart) == SEG_LAST));

  p_in_segment_r1: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadEn |=> (ADDR_W'(physAddr - segStart) < SEG_SPAN));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.loadEn |=> ($stable(physAddr) && $stable(segSel) && $stable(segEnd)));

  p_fetch_cs_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.loadEn && modeCode == MODE_FETCH) |=> (segSel == SEG_CS));

  p_push_ss_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.loadEn && modeCode == MODE_PUSH) |=> (segSel == SEG_SS));

  p_override_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.loadEn && ovrEn && modeCode != MODE_FETCH && modeCode != MODE_PUSH)
      |=> (segSel == $past(ovrSeg)));

endmodule

// File: rtl/segAddrGen.sv
module segAddrGen
  import segAddrPkg::*;
#(
  parameter int REG_W     = 16,
  parameter int SHIFT     = 4,
  parameter int PUSH_STEP = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  input  logic [2:0]             modeCode,
  input  logic [1:0]             ptrSel,
  input  logic                   baseSel,
  input  logic                   idxSel,
  input  logic                   ovrEn,
  input  logic [1:0]             ovrSeg,
  input  logic [REG_W-1:0]       bxVal,
  input  logic [REG_W-1:0]       bpVal,
  input  logic [REG_W-1:0]       siVal,
  input  logic [REG_W-1:0]       diVal,
  input  logic [REG_W-1:0]       spVal,
  input  logic [REG_W-1:0]       ipVal,
  input  logic [REG_W-1:0]       disp,
  input  logic [REG_W-1:0]       esVal,
  input  logic [REG_W-1:0]       csVal,
  input  logic [REG_W-1:0]       ssVal,
  input  logic [REG_W-1:0]       dsVal,
  output logic                   outValid,
  output logic [REG_W+SHIFT-1:0] physAddr,
  output logic [1:0]             segSel,
  output logic [REG_W+SHIFT-1:0] segStart,
  output logic [REG_W+SHIFT-1:0] segEnd
);

  ctlStrobe_t ctl;

  segAddrCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .ctl(ctl), .outValid(outValid)
  );

  segAddrDatapath #(.REG_W(REG_W), .SHIFT(SHIFT), .PUSH_STEP(PUSH_STEP)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .modeCode(modeCode), .ptrSel(ptrSel), .baseSel(baseSel), .idxSel(idxSel),
    .ovrEn(ovrEn), .ovrSeg(ovrSeg),
    .bxVal(bxVal), .bpVal(bpVal), .siVal(siVal), .diVal(diVal),
    .spVal(spVal), .ipVal(ipVal), .disp(disp),
    .esVal(esVal), .csVal(csVal), .ssVal(ssVal), .dsVal(dsVal),
    .physAddr(physAddr), .segSel(segSel), .segStart(segStart), .segEnd(segEnd)
  );

endmodule

// File: tb/segAddrGen_tb.sv
`timescale 1ns/1ps
module segAddrGen_tb;

  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic        rstN, reqValid, baseSel, idxSel, ovrEn;
  logic [2:0]  modeCode;
  logic [1:0]  ptrSel, ovrSeg;
  logic [15:0] bxVal, bpVal, siVal, diVal, spVal, ipVal, disp;
  logic [15:0] esVal, csVal, ssVal, dsVal;
  logic        outValid;
  logic [19:0] physAddr, segStart, segEnd;
  logic [1:0]  segSel;

  segAddrGen u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .modeCode(modeCode),
    .ptrSel(ptrSel), .baseSel(baseSel), .idxSel(idxSel), .ovrEn(ovrEn), .ovrSeg(ovrSeg),
    .bxVal(bxVal), .bpVal(bpVal), .siVal(siVal), .diVal(diVal), .spVal(spVal),
    .ipVal(ipVal), .disp(disp), .esVal(esVal), .csVal(csVal), .ssVal(ssVal),
    .dsVal(dsVal), .outValid(outValid), .physAddr(physAddr), .segSel(segSel),
    .segStart(segStart), .segEnd(segEnd)
  );

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp<=150000 cycles", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // expected values from the requirements
  int expPhys, expSeg, expStart, expEnd;

  task automatic model();
    int off, sv, ptr, seg;
    logic bpUsed;
    case (ptrSel)
      2'd0: ptr = bxVal;
      2'd1: ptr = bpVal;
      2'd2: ptr = siVal;
      default: ptr = diVal;
    endcase
    bpUsed = 1'b0;
    case (modeCode)
      3'd1: begin off = ptr; bpUsed = (ptrSel == 2'd1); end
      3'd2: begin off = ptr + disp; bpUsed = (ptrSel == 2'd1); end
      3'd3: begin off = (baseSel ? bpVal : bxVal) + (idxSel ? diVal : siVal); bpUsed = baseSel; end
      3'd4: off = ipVal;
      3'd5: off = spVal - 2;
      default: off = disp;
    endcase
    off = off & 32'hFFFF;
    if (modeCode == 3'd4) seg = 1;
    else if (modeCode == 3'd5) seg = 2;
    else if (ovrEn) seg = ovrSeg;
    else seg = bpUsed ? 2 : 3;
    case (seg)
      0: sv = esVal;
      1: sv = csVal;
      2: sv = ssVal;
      default: sv = dsVal;
    endcase
    expSeg   = seg;
    expStart = (sv * 16) & 32'hFFFFF;
    expPhys  = (sv * 16 + off) & 32'hFFFFF;
    expEnd   = (sv * 16 + 32'hFFFF) & 32'hFFFFF;
  endtask

  function automatic string modeTag(logic [2:0] m);
    case (m)
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R8";
      3'd5: return "R9";
      default: return "R2";
    endcase
  endfunction

  // issue at a negedge, check at the next negedge, then an idle cycle
  task automatic runReq();
    logic [19:0] held;
    logic [1:0]  heldSeg;
    string mt;
    model();
    mt = modeTag(modeCode);
    reqValid = 1'b1;
    @(negedge clk);
    chk("R11 outValid after req", 32'(outValid), 32'd1);
    chk({mt, " R1 physAddr"}, 32'(physAddr), expPhys);
    if (modeCode == 3'd4 || modeCode == 3'd5) chk({mt, " segSel ovr ignored"}, 32'(segSel), expSeg);
    else if (ovrEn) chk("R7 segSel override", 32'(segSel), expSeg);
    else chk("R6 segSel implicit", 32'(segSel), expSeg);
    chk("R10 segStart", 32'(segStart), expStart);
    chk("R10 segEnd", 32'(segEnd), expEnd);
    held = physAddr;
    heldSeg = segSel;
    reqValid = 1'b0;
    disp = ~disp; dsVal = dsVal ^ 16'h5A5A; ssVal = ssVal + 16'h0101;
    modeCode = modeCode ^ 3'd3; ovrEn = ~ovrEn;
    @(negedge clk);
    chk("R11 outValid idle", 32'(outValid), 32'd0);
    chk("R11 physAddr hold", 32'(physAddr), 32'(held));
    chk("R11 segSel hold", 32'(segSel), 32'(heldSeg));
  endtask

  task automatic setPat(int pat, int k);
    case (pat)
      0: begin
        bxVal = 16'h0100; bpVal = 16'h1000; siVal = 16'h0200; diVal = 16'h0030;
        spVal = 16'h0100; ipVal = 16'h1000; disp = 16'h0040;
        esVal = 16'h3000; csVal = 16'h2000; ssVal = 16'h4000; dsVal = 16'h1000;
      end
      1: begin
        bxVal = 16'hFFF0; bpVal = 16'hFFE0; siVal = 16'hFF00; diVal = 16'hF0F0;
        spVal = 16'h0001; ipVal = 16'hFFFF; disp = 16'h0123;
        esVal = 16'hFFFF; csVal = 16'hF800; ssVal = 16'hFFF8; dsVal = 16'hF001;
      end
      default: begin
        bxVal = 16'(k * 40503 + 7);   bpVal = 16'(k * 30011 + 3);
        siVal = 16'(k * 22367 + 11);  diVal = 16'(k * 51749 + 5);
        spVal = 16'(k * 12345);       ipVal = 16'(k * 33331 + 1);
        disp  = 16'(k * 9973 + 13);
        esVal = 16'(k * 4099 + 1);    csVal = 16'(k * 7919 + 2);
        ssVal = 16'(k * 6007 + 3);    dsVal = 16'(k * 2999 + 4);
      end
    endcase
  endtask

  initial begin
    int k;
    rstN = 1'b0; reqValid = 1'b0; modeCode = 3'd0; ptrSel = 2'd0;
    baseSel = 1'b0; idxSel = 1'b0; ovrEn = 1'b0; ovrSeg = 2'd0;
    setPat(0, 0);
    repeat (3) @(negedge clk);
    chk("R12 outValid in reset", 32'(outValid), 32'd0);
    chk("R12 physAddr in reset", 32'(physAddr), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R12 outValid after reset", 32'(outValid), 32'd0);
    chk("R12 segEnd after reset", 32'(segEnd), 32'd0);
    chk("R12 segStart after reset", 32'(segStart), 32'd0);

    // directed: SS=2000 BP=1000 DI=0100 -> 21100
    setPat(0, 0);
    ssVal = 16'h2000; bpVal = 16'h1000; diVal = 16'h0100;
    modeCode = 3'd3; baseSel = 1'b1; idxSel = 1'b1; ovrEn = 1'b0;
    reqValid = 1'b1; @(negedge clk); reqValid = 1'b0;
    chk("R5 R6 SS:BP+DI", 32'(physAddr), 32'h21100);
    chk("R6 BP picks SS", 32'(segSel), 32'd2);

    // directed: CS=2000 IP=1000 -> 21000 even with override
    csVal = 16'h2000; ipVal = 16'h1000; modeCode = 3'd4; ovrEn = 1'b1; ovrSeg = 2'd0;
    reqValid = 1'b1; @(negedge clk); reqValid = 1'b0;
    chk("R8 CS:IP fetch", 32'(physAddr), 32'h21000);
    chk("R8 fetch seg CS", 32'(segSel), 32'd1);

    // directed: DS=1000 spans 10000..1FFFF
    dsVal = 16'h1000; modeCode = 3'd0; ovrEn = 1'b0; disp = 16'h0000;
    reqValid = 1'b1; @(negedge clk); reqValid = 1'b0;
    chk("R10 span start", 32'(segStart), 32'h10000);
    chk("R10 span end", 32'(segEnd), 32'h1FFFF);

    // directed: push at SP=0 wraps to FFFE
    ssVal = 16'h3000; spVal = 16'h0000; modeCode = 3'd5;
    reqValid = 1'b1; @(negedge clk); reqValid = 1'b0;
    chk("R9 push wrap", 32'(physAddr), 32'h3FFFE);

    // directed: segment FFFF end wraps past 2^20
    dsVal = 16'hFFFF; modeCode = 3'd0; disp = 16'h0020;
    reqValid = 1'b1; @(negedge clk); reqValid = 1'b0;
    chk("R1 address wrap", 32'(physAddr), 32'h00010);
    chk("R10 end wrap", 32'(segEnd), 32'h0FFEF);
    @(negedge clk);

    // sweep
    k = 0;
    for (int m = 0; m < 8; m++)
      for (int p = 0; p < 4; p++)
        for (int b = 0; b < 2; b++)
          for (int x = 0; x < 2; x++)
            for (int oe = 0; oe < 2; oe++)
              for (int os = 0; os < 4; os++)
                for (int pat = 0; pat < 3; pat++) begin
                  setPat(pat, k);
                  k++;
                  modeCode = 3'(m); ptrSel = 2'(p); baseSel = b[0]; idxSel = x[0];
                  ovrEn = oe[0]; ovrSeg = 2'(os);
                  runReq();
                end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule